// File: doc/BRIEF.md
# Segmented Instruction Prefetch Unit

This block reads instruction bytes ahead of the execution stage so that execution does not stall on memory. It holds a 16-bit code segment and a 16-bit fetch offset. From these it forms a 20-bit physical address: the segment moved up four bit positions, plus the offset. It reads 16-bit words through a memory read port and stores the bytes in a six-entry byte queue. The execution stage takes bytes from the head of the queue one at a time. Instructions vary in length, so the consumer never assumes a fixed number of bytes per instruction.

Fetching runs alongside consumption. A new word read starts whenever at least two queue slots are free, even if the queue still holds bytes. After a taken branch, the consumer drives a redirect with a new segment and offset. The redirect empties the queue at once, discards any read that is still in flight, and fetching resumes from the new location. If the redirect offset is odd, the first read delivers only the upper byte of its word. All later reads are word aligned.

Top module: `seg_prefetch_unit`

## Requirements
- R1: `memAddr` equals `{segment, 4'h0}` plus the zero-extended offset, truncated to 20 bits. Examples: 456A:1620 gives 46CC0, and FFFF:0015 wraps to 00005.
- R2: The memory returns the word at the requested address with bit 0 cleared. Bits [7:0] hold the even-address byte. For an even offset, the response adds the low byte and then the high byte to the queue, and the offset advances by 2.
- R3: For an odd offset, the response adds only bits [15:8] to the queue and the offset advances by 1. The next request is then word aligned.
- R4: The queue never holds more than 6 bytes. `memReq` is asserted only when at least 2 slots are free.
- R5: At most one read is outstanding at a time. `memReq` stays high until `memReady` accepts it. No new request is raised until `memRdValid` returns the data for the accepted read.
- R6: With no read outstanding, no redirect and at least 2 free slots, `memReq` is high even while the queue holds bytes.
- R7: `byteValid` is high exactly when the queue is not empty. `byteData` shows the oldest byte, and bytes leave in fetch order, one per cycle with `bytePop`.
- R8: A `bytePop` while `byteValid` is low has no effect.
- R9: In a cycle with `flushValid` high, `memReq` is low and `bytePop` and `memRdValid` are ignored. On the next cycle the queue is empty and fetching uses `flushSeg:flushOff`. A response for a read accepted before the redirect is discarded, and no request is raised until that response arrives.
- R10: After reset the queue is empty, the segment is FFFF, the offset is 0000, and a request to FFFF0 is raised at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flushValid | input | 1 | Redirect strobe |
| flushSeg | input | 16 | New code segment on redirect |
| flushOff | input | 16 | New fetch offset on redirect |
| memReq | output | 1 | Read request |
| memAddr | output | 20 | Physical byte address of the read |
| memReady | input | 1 | Memory accepts the request this cycle |
| memRdValid | input | 1 | Read data strobe |
| memRdData | input | 16 | Read word, even byte in bits [7:0] |
| byteValid | output | 1 | Queue head is valid |
| byteData | output | 8 | Queue head byte |
| bytePop | input | 1 | Consume the head byte |

## Verification
The embedded assertions check, on every cycle, the properties that span a single cycle or one cycle ahead:
- queue occupancy stays within six entries;
- a request is held until it is accepted;
- a request is never issued in the cycle right after an acceptance;
- a redirect leaves the queue empty;
- a pop on an empty queue with no incoming data leaves the queue empty.

Other behaviours depend on data values and on long sequences, so only the bench's scenarios can show them. These include the address arithmetic and its wrap past FFFFF, the odd-offset single-byte fill, byte order in the queue, and the discarding of a response that returns after a redirect. The bench covers them with a queue-based reference that it compares on every clock.

// File: rtl/pfetch_pkg.sv
package pfetch_pkg;
  typedef struct packed {
    logic load;
    logic issue;
    logic pushPair;
    logic pushHigh;
    logic pop;
  } pfStrobe_t;
endpackage

// File: rtl/pf_datapath.sv
module pf_datapath
  import pfetch_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int ADDR_W = 20,
  parameter int QUEUE_DEPTH = 6,
  parameter logic [SEG_W-1:0] RESET_SEG = 16'hFFFF,
  parameter logic [SEG_W-1:0] RESET_OFF = 16'h0000,
  localparam int CNT_W = $clog2(QUEUE_DEPTH + 1),
  localparam int PTR_W = $clog2(QUEUE_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfStrobe_t         strb,
  input  logic [SEG_W-1:0]  flushSeg,
  input  logic [SEG_W-1:0]  flushOff,
  input  logic [15:0]       rdData,
  output logic [ADDR_W-1:0] physAddr,
  output logic              offLsb,
  output logic [CNT_W-1:0]  qCount,
  output logic [7:0]        headByte
);
  localparam int SHIFT = ADDR_W - SEG_W;

  logic [SEG_W-1:0] segReg, offReg;
  logic [PTR_W-1:0] rdPtr, wrPtr, wrPtr1;
  logic [7:0]       slots [QUEUE_DEPTH];

  function automatic logic [PTR_W-1:0] wrapInc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(QUEUE_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Address adder: carry beyond the top address bit is dropped.
  assign physAddr = {segReg, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, offReg};
  assign offLsb   = offReg[0];
  assign headByte = slots[rdPtr];
  assign wrPtr1   = wrapInc(wrPtr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segReg <= RESET_SEG;
      offReg <= RESET_OFF;
    end else if (strb.load) begin
      segReg <= flushSeg;
      offReg <= flushOff;
    end else if (strb.pushPair) begin
      offReg <= offReg + SEG_W'(2);
    end else if (strb.pushHigh) begin
      offReg <= offReg + SEG_W'(1);
    end
  end

  // Per-slot write ports: first byte at wrPtr, second byte of a pair at wrPtr+1.
  for (genvar i = 0; i < QUEUE_DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slots[i] <= '0;
      end else if (strb.pushPair && wrPtr == PTR_W'(i)) begin
        slots[i] <= rdData[7:0];
      end else if (strb.pushPair && wrPtr1 == PTR_W'(i)) begin
        slots[i] <= rdData[15:8];
      end else if (strb.pushHigh && wrPtr == PTR_W'(i)) begin
        slots[i] <= rdData[15:8];
      end
    end
  end

  logic [CNT_W-1:0] addN, subN;
  assign addN = strb.pushPair ? CNT_W'(2) : (strb.pushHigh ? CNT_W'(1) : '0);
  assign subN = strb.pop ? CNT_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (!rstN || strb.load) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      qCount <= '0;
    end else begin
      if (strb.pop) rdPtr <= wrapInc(rdPtr);
      if (strb.pushPair) wrPtr <= wrapInc(wrPtr1);
      else if (strb.pushHigh) wrPtr <= wrPtr1;
      qCount <= qCount + addN - subN;
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= CNT_W'(QUEUE_DEPTH));

  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (qCount == '0 && !strb.pushPair && !strb.pushHigh) |=> qCount == '0);
endmodule

// File: rtl/pf_control.sv
module pf_control
  import pfetch_pkg::*;
#(
  parameter int QUEUE_DEPTH = 6,
  localparam int CNT_W = $clog2(QUEUE_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flushValid,
  input  logic             memReady,
  input  logic             memRdValid,
  input  logic             bytePop,
  input  logic [CNT_W-1:0] qCount,
  input  logic             offLsb,
  output logic             memReq,
  output pfStrobe_t        strb
);
  logic waitResp, staleResp, oddReq, respUsed;

  assign memReq = !waitResp && !staleResp && !flushValid &&
                  (qCount <= CNT_W'(QUEUE_DEPTH - 2));
  assign respUsed = !flushValid && memRdValid && waitResp && !staleResp;

  always_comb begin
    strb          = '0;
    strb.load     = flushValid;
    strb.issue    = memReq && memReady;
    strb.pushPair = respUsed && !oddReq;
    strb.pushHigh = respUsed && oddReq;
    strb.pop      = !flushValid && bytePop && (qCount != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitResp  <= 1'b0;
      staleResp <= 1'b0;
      oddReq    <= 1'b0;
    end else if (flushValid) begin
      waitResp  <= 1'b0;
      staleResp <= (waitResp || staleResp) && !memRdValid;
    end else begin
      if (memRdValid) begin
        waitResp  <= 1'b0;
        staleResp <= 1'b0;
      end
      if (strb.issue) begin
        waitResp <= 1'b1;
        oddReq   <= offLsb;
      end
    end
  end

  assert_single_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady) |=> !memReq);

  assert_hold_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq || flushValid));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> qCount == '0);
endmodule

// File: rtl/seg_prefetch_unit.sv
module seg_prefetch_unit
  import pfetch_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int ADDR_W = 20,
  parameter int QUEUE_DEPTH = 6,
  parameter logic [SEG_W-1:0] RESET_SEG = 16'hFFFF,
  parameter logic [SEG_W-1:0] RESET_OFF = 16'h0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushValid,
  input  logic [SEG_W-1:0]  flushSeg,
  input  logic [SEG_W-1:0]  flushOff,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memReady,
  input  logic              memRdValid,
  input  logic [15:0]       memRdData,
  output logic              byteValid,
  output logic [7:0]        byteData,
  input  logic              bytePop
);
  localparam int CNT_W = $clog2(QUEUE_DEPTH + 1);

  pfStrobe_t        strb;
  logic [CNT_W-1:0] qCount;
  logic             offLsb;

  pf_control #(.QUEUE_DEPTH(QUEUE_DEPTH)) u_control (
    .clk(clk), .rstN(rstN), .flushValid(flushValid), .memReady(memReady),
    .memRdValid(memRdValid), .bytePop(bytePop), .qCount(qCount),
    .offLsb(offLsb), .memReq(memReq), .strb(strb)
  );

  pf_datapath #(
    .SEG_W(SEG_W), .ADDR_W(ADDR_W), .QUEUE_DEPTH(QUEUE_DEPTH),
    .RESET_SEG(RESET_SEG), .RESET_OFF(RESET_OFF)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .flushSeg(flushSeg),
    .flushOff(flushOff), .rdData(memRdData), .physAddr(memAddr),
    .offLsb(offLsb), .qCount(qCount), .headByte(byteData)
  );

  assign byteValid = (qCount != '0);
endmodule

// File: tb/test_seg_prefetch_unit.sv
`timescale 1ns/1ps
module test_seg_prefetch_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flushValid = 1'b0;
  logic [15:0] flushSeg = '0, flushOff = '0;
  logic        memReq, memReady = 1'b0, memRdValid = 1'b0;
  logic [19:0] memAddr;
  logic [15:0] memRdData = '0;
  logic        byteValid, bytePop = 1'b0;
  logic [7:0]  byteData;

  seg_prefetch_unit i_seg_prefetch_unit (
    .clk(clk), .rstN(rstN), .flushValid(flushValid), .flushSeg(flushSeg),
    .flushOff(flushOff), .memReq(memReq), .memAddr(memAddr),
    .memReady(memReady), .memRdValid(memRdValid), .memRdData(memRdData),
    .byteValid(byteValid), .byteData(byteData), .bytePop(bytePop)
  );

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // Reference state
  logic [7:0]  refQ[$];
  logic [15:0] refSeg, refOff;
  bit          refOut, refStale, refOdd;
  // Memory model state
  bit          memPend;
  int          memLat;
  logic [19:0] memPendAddr;
  // Observed values of the last cycle
  logic        obsReq, obsValid;
  logic [19:0] obsAddr;
  logic [7:0]  obsData;

  function automatic logic [7:0] byteAt(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
  endfunction

  function automatic logic [19:0] refPhys(input logic [15:0] s, input logic [15:0] o);
    logic [20:0] sum;
    sum = {1'b0, s, 4'h0} + {5'h0, o};
    return sum[19:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    refQ.delete();
    refSeg = 16'hFFFF; refOff = 16'h0000;
    refOut = 0; refStale = 0; refOdd = 0;
    memPend = 0; memLat = 0; memPendAddr = '0;
  endtask

  // One clock: drive at negedge, compare, update model at posedge.
  task automatic cycle(input bit fl, input logic [15:0] fs, input logic [15:0] fo,
                       input bit pop, input bit rdy);
    bit    expReq;
    bit    popOk;
    string reqTag;
    @(negedge clk);
    flushValid = fl; flushSeg = fs; flushOff = fo; bytePop = pop; memReady = rdy;
    memRdValid = 1'b0;
    if (memPend) begin
      if (memLat == 0) begin
        memRdValid = 1'b1;
        memRdData = {byteAt({memPendAddr[19:1], 1'b1}), byteAt({memPendAddr[19:1], 1'b0})};
      end else memLat--;
    end
    #1;
    expReq = !refOut && !refStale && !fl && (6 - refQ.size() >= 2);
    obsReq = memReq; obsAddr = memAddr; obsValid = byteValid; obsData = byteData;
    if (refOut || refStale) reqTag = "R5";
    else if (fl) reqTag = "R9";
    else if (6 - refQ.size() < 2) reqTag = "R4";
    else reqTag = "R6";
    check(memReq == expReq, reqTag, "memReq", 32'(memReq), 32'(expReq));
    if (expReq)
      check(memAddr == refPhys(refSeg, refOff), "R1", "memAddr",
            32'(memAddr), 32'(refPhys(refSeg, refOff)));
    check(byteValid == (refQ.size() != 0), refQ.size() == 0 ? "R8" : "R7",
          "byteValid", 32'(byteValid), 32'(refQ.size() != 0));
    if (refQ.size() != 0)
      check(byteData == refQ[0], "R2", "byteData", 32'(byteData), 32'(refQ[0]));
    @(posedge clk);
    if (memRdValid) memPend = 0;
    if (fl) begin
      refQ.delete();
      refSeg = fs; refOff = fo;
      refStale = (refOut || refStale) && !memRdValid;
      refOut = 0;
    end else begin
      popOk = pop && refQ.size() != 0;
      if (popOk) void'(refQ.pop_front());
      if (memRdValid) begin
        if (refStale) refStale = 0;
        else if (refOut) begin
          if (refOdd) begin
            refQ.push_back(memRdData[15:8]); refOff = refOff + 16'd1;
          end else begin
            refQ.push_back(memRdData[7:0]); refQ.push_back(memRdData[15:8]);
            refOff = refOff + 16'd2;
          end
          refOut = 0;
        end
      end
      if (expReq && rdy) begin
        refOut = 1; refOdd = refOff[0];
        memPend = 1; memLat = int'($urandom % 3); memPendAddr = refPhys(refSeg, refOff);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R5 watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R10: reset state
    cycle(0, 0, 0, 0, 0);
    check(obsValid == 0, "R10", "byteValid after reset", 32'(obsValid), 0);
    check(obsReq == 1, "R10", "memReq after reset", 32'(obsReq), 1);
    check(obsAddr == 20'hFFFF0, "R10", "reset address", 32'(obsAddr), 32'h FFFF0);
    // Fill without consuming (R4)
    for (int i = 0; i < 20; i++) cycle(0, 0, 0, 0, 1);
    check(obsValid == 1 && obsReq == 0, "R4", "full queue stops requests",
          {obsValid, obsReq}, 32'h2);
    cycle(0, 0, 0, 1, 1);
    check(obsReq == 0, "R4", "one free slot still blocks", 32'(obsReq), 0);
    cycle(0, 0, 0, 1, 0);
    cycle(0, 0, 0, 0, 0);
    check(obsReq == 1 && obsValid == 1, "R6", "request while bytes queued",
          {obsReq, obsValid}, 32'h3);
    // Redirect with pop in the same cycle (R9, R1)
    cycle(1, 16'h456A, 16'h1620, 1, 1);
    check(obsReq == 0, "R9", "no request during redirect", 32'(obsReq), 0);
    cycle(0, 0, 0, 1, 0);
    check(obsValid == 0, "R9", "queue empty after redirect", 32'(obsValid), 0);
    check(obsAddr == 20'h46CC0, "R1", "456A:1620", 32'(obsAddr), 32'h46CC0);
    // Odd offset with wrap (R1, R3), pops on empty (R8)
    cycle(1, 16'hFFFF, 16'h0015, 1, 0);
    cycle(0, 0, 0, 1, 0);
    check(obsAddr == 20'h00005, "R1", "wrapped address", 32'(obsAddr), 32'h5);
    check(obsValid == 0, "R8", "pop on empty ignored", 32'(obsValid), 0);
    cycle(0, 0, 0, 0, 1);
    for (int i = 0; i < 6 && !obsValid; i++) cycle(0, 0, 0, 0, 0);
    check(obsValid == 1 && obsData == byteAt(20'h00005), "R3", "odd fetch gives upper byte",
          32'(obsData), 32'(byteAt(20'h00005)));
    check(obsReq == 1 && obsAddr == 20'h00006, "R3", "aligned follow-on address",
          32'(obsAddr), 32'h6);
    // Redirect while a read is in flight: its data is dropped (R9)
    cycle(0, 0, 0, 0, 1);
    cycle(1, 16'h1234, 16'h0100, 0, 1);
    for (int i = 0; i < 8; i++) cycle(0, 0, 0, 0, 1);
    check(obsValid == 1 && obsData == byteAt(20'h12440), "R9", "new stream head",
          32'(obsData), 32'(byteAt(20'h12440)));
    // Randomized mix (R2, R5, R6, R7)
    for (int i = 0; i < 4000; i++) begin
      bit fl;
      fl = ($urandom % 37) == 0;
      cycle(fl, 16'($urandom), 16'($urandom), (i % 900 < 300) ? ($urandom % 5 == 0) : ($urandom % 3 != 0),
            $urandom % 4 != 0);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule